// File: doc/BRIEF.md
# Triggered Multichannel Scan Sequencer

This block runs an acquisition for a multichannel sampling front end. The host first loads a small scan list one word at a time. Each word gives a channel number, a three-bit amplifier gain code, an input range bit and an end-of-list flag. The host also loads a sample count, picks a trigger source and then leaves the block armed.

When a trigger is accepted, a run begins. Each tick from an external sample-interval timer advances the run by one scan-list entry. On that tick the block drives the entry's settings to the front end, raises a one-cycle conversion request, and counts down the remaining samples. A conversion-done pulse from the converter clears the busy flag.

When the last sample completes, the block returns to its armed state with the sample count still in place, so another trigger starts a fresh run. An optional lockout refuses new triggers until software acknowledges the previous run. A tick that arrives while a conversion is still outstanding is recorded in a sticky overrun flag.

Top module: `acq_scan_seq`

## Requirements
- R1: A scan-list word holds the channel in bits [5:0], the gain code in bits [8:6], the range bit in bit 9 and the end-of-list flag in bit 10. A tick accepted during a run raises `conv_req_o` for exactly one cycle, one clock edge after the tick is sampled. In that same cycle `chan_o`, `gain_o` and `range_o` show the current entry, and they hold those values until the next accepted tick.
- R2: After the entry whose end-of-list flag is set has been issued, the next conversion uses entry 0.
- R3: While `bus_mode_i` is 1, only `bus_trig_i` can start a run. Both `start_wr_i` and edges on `ext_trig_ni` are ignored.
- R4: While `bus_mode_i` is 0, a run starts on `start_wr_i` or on a high-to-low transition of `ext_trig_ni`. For a start strobe, `running_o` rises at the sampling edge. For the external input, which passes through a two-flop synchronizer, `running_o` rises at the third edge that samples the input low.
- R5: While `ext_dis_i` is 1, falling edges on `ext_trig_ni` start no run.
- R6: `in_prog_o` is set when a run starts and stays set after the run ends, until `ack_i` arrives while no run is active. While `retrig_dis_i` is 1 and `in_prog_o` is 1, every trigger is refused. A trigger that arrives during a run never restarts it.
- R7: `cnt_load_i` stores N-1 from `cnt_value_i`. A run issues exactly N conversions, and `running_o` falls at the edge that samples the conversion-done pulse of the Nth one. A later trigger starts another N-sample run without a new load.
- R8: `busy_o` is 1 from the cycle of `conv_req_o` until the edge that samples `conv_done_i`.
- R9: Scan-list writes are ignored while a run is active. `wptr_clr_i` returns the write pointer to entry 0, and each accepted write advances it by one.
- R10: Ticks are ignored outside a run. A tick during a run while `busy_o` is 1 issues nothing and sets `overrun_o`, which stays set until `ack_i`.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Scan-list word write strobe |
| cfg_data_i | input | 11 | Scan-list word (layout in R1) |
| wptr_clr_i | input | 1 | Reset the write pointer to entry 0 |
| cnt_load_i | input | 1 | Load the sample count |
| cnt_value_i | input | 16 | Sample count minus one |
| bus_mode_i | input | 1 | Select the inter-board bus trigger as the only trigger source |
| ext_dis_i | input | 1 | Ignore the external trigger input |
| retrig_dis_i | input | 1 | Enable the retrigger lockout |
| start_wr_i | input | 1 | Software start strobe |
| ext_trig_ni | input | 1 | Asynchronous external trigger, active on its falling edge |
| bus_trig_i | input | 1 | Inter-board bus trigger pulse |
| ack_i | input | 1 | Software acknowledge: clears the in-progress and overrun flags |
| tick_i | input | 1 | Sample-interval tick |
| conv_done_i | input | 1 | Conversion-complete pulse |
| conv_req_o | output | 1 | Conversion request pulse |
| chan_o | output | 6 | Channel of the active entry |
| gain_o | output | 3 | Gain code of the active entry |
| range_o | output | 1 | Range bit of the active entry |
| busy_o | output | 1 | Conversion pending |
| running_o | output | 1 | Run active |
| in_prog_o | output | 1 | Acquisition-in-progress status |
| overrun_o | output | 1 | Sticky tick overrun |

## Verification
The timing of each result is fixed relative to its stimulus:
- A conversion request and the entry settings appear one clock edge after the tick.
- `running_o` and `in_prog_o` follow a start strobe or a bus trigger after one edge, and follow an external-trigger fall after three edges.
- `busy_o` and, at the final sample, `running_o` drop one edge after the conversion-done pulse.

The bench keeps a behavioural model that advances at every rising edge. Every output is compared with that model at the following falling edge. Directed checks drive inputs at falling edges and read the outputs one falling edge later, or after the three-edge synchronizer delay, as listed above.

// File: rtl/acq_scan_pkg.sv
package acq_scan_pkg;
   localparam int unsigned GAIN_W = 3;
   localparam int unsigned FLAG_W = 2;

   function automatic int unsigned entry_width(input int unsigned ch_w);
      return ch_w + GAIN_W + FLAG_W;
   endfunction
endpackage

// File: rtl/acq_scan_trig.sv
module acq_scan_trig #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ext_trig_ni,
   input  logic bus_mode_i,
   input  logic ext_dis_i,
   input  logic start_wr_i,
   input  logic bus_trig_i,
   output logic trig_o
);
   localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

   logic [CHAIN_W-1:0] chain_q;
   logic               ext_fall;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("acq_scan_trig: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // The synchronizer stages plus one delay flop for edge detection; the line idles high.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[CHAIN_W-2:0], ext_trig_ni};
   end

   assign ext_fall = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

   always_comb begin
      if (bus_mode_i) trig_o = bus_trig_i;
      else            trig_o = start_wr_i | (ext_fall & ~ext_dis_i);
   end
endmodule

// File: rtl/acq_scan_cfg_mem.sv
module acq_scan_cfg_mem #(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned ENTRY_W = 11,
   localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               we_i,
   input  logic [ENTRY_W-1:0] wdata_i,
   input  logic               wptr_clr_i,
   input  logic               lock_i,
   input  logic [IDX_W-1:0]   rd_idx_i,
   output logic [ENTRY_W-1:0] rd_data_o
);
   logic [ENTRY_W-1:0] mem_q [DEPTH];
   logic [IDX_W-1:0]   wptr_q;
   logic               wr_ok;

   assign wr_ok = we_i & ~lock_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wptr_q <= '0;
      end else if (wptr_clr_i) begin
         wptr_q <= '0;
      end else if (wr_ok) begin
         if (wptr_q == IDX_W'(DEPTH - 1)) wptr_q <= '0;
         else                            wptr_q <= wptr_q + 1'b1;
      end
   end

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_word
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                               mem_q[e] <= '0;
            else if (wr_ok && wptr_q == IDX_W'(e))     mem_q[e] <= wdata_i;
         end
      end
   endgenerate

   assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/acq_scan_run.sv
module acq_scan_run
   import acq_scan_pkg::*;
#(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned CH_W    = 6,
   localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned ENTRY_W = CH_W + GAIN_W + FLAG_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               trig_i,
   input  logic               retrig_dis_i,
   input  logic               ack_i,
   input  logic               tick_i,
   input  logic               conv_done_i,
   input  logic               cnt_load_i,
   input  logic [CNT_W-1:0]   cnt_value_i,
   input  logic [ENTRY_W-1:0] entry_i,
   output logic [IDX_W-1:0]   idx_o,
   output logic               conv_req_o,
   output logic [CH_W-1:0]    chan_o,
   output logic [GAIN_W-1:0]  gain_o,
   output logic               range_o,
   output logic               busy_o,
   output logic               running_o,
   output logic               in_prog_o,
   output logic               overrun_o
);
   typedef struct packed {
      logic              last;
      logic              rng;
      logic [GAIN_W-1:0] gain;
      logic [CH_W-1:0]   chan;
   } entry_t;

   entry_t           ent;
   logic [CNT_W-1:0] reload_q, remain_q;
   logic             final_q;
   logic             accept, issue, finish;

   assign ent    = entry_t'(entry_i);
   assign accept = trig_i & ~running_o & ~(retrig_dis_i & in_prog_o);
   assign issue  = tick_i & running_o & ~busy_o & ~final_q;
   assign finish = conv_done_i & busy_o & final_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) reload_q <= '0;
      else if (cnt_load_i) reload_q <= cnt_value_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         running_o <= 1'b0;
         final_q   <= 1'b0;
         remain_q  <= '0;
         idx_o     <= '0;
      end else if (accept) begin
         running_o <= 1'b1;
         final_q   <= 1'b0;
         remain_q  <= reload_q;
         idx_o     <= '0;
      end else begin
         if (finish) begin
            running_o <= 1'b0;
            final_q   <= 1'b0;
         end
         if (issue) begin
            if (remain_q == '0) final_q  <= 1'b1;
            else                remain_q <= remain_q - 1'b1;
            if (ent.last || idx_o == IDX_W'(DEPTH - 1)) idx_o <= '0;
            else                                        idx_o <= idx_o + 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         conv_req_o <= 1'b0;
         busy_o     <= 1'b0;
         chan_o     <= '0;
         gain_o     <= '0;
         range_o    <= 1'b0;
      end else begin
         conv_req_o <= issue;
         if (issue) begin
            busy_o  <= 1'b1;
            chan_o  <= ent.chan;
            gain_o  <= ent.gain;
            range_o <= ent.rng;
         end else if (conv_done_i) begin
            busy_o  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         in_prog_o <= 1'b0;
         overrun_o <= 1'b0;
      end else begin
         if (accept)                  in_prog_o <= 1'b1;
         else if (ack_i && !running_o) in_prog_o <= 1'b0;
         if (tick_i && running_o && busy_o) overrun_o <= 1'b1;
         else if (ack_i)                    overrun_o <= 1'b0;
      end
   end
endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq
   import acq_scan_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned CH_W        = 6,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned ENTRY_W = CH_W + GAIN_W + FLAG_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cfg_we_i,
   input  logic [ENTRY_W-1:0] cfg_data_i,
   input  logic               wptr_clr_i,
   input  logic               cnt_load_i,
   input  logic [CNT_W-1:0]   cnt_value_i,
   input  logic               bus_mode_i,
   input  logic               ext_dis_i,
   input  logic               retrig_dis_i,
   input  logic               start_wr_i,
   input  logic               ext_trig_ni,
   input  logic               bus_trig_i,
   input  logic               ack_i,
   input  logic               tick_i,
   input  logic               conv_done_i,
   output logic               conv_req_o,
   output logic [CH_W-1:0]    chan_o,
   output logic [GAIN_W-1:0]  gain_o,
   output logic               range_o,
   output logic               busy_o,
   output logic               running_o,
   output logic               in_prog_o,
   output logic               overrun_o
);
   generate
      if (DEPTH < 2)                     begin : g_bad_depth $error("acq_scan_seq: DEPTH must be at least 2"); end
      if (CNT_W < 2)                     begin : g_bad_cnt   $error("acq_scan_seq: CNT_W must be at least 2"); end
      if (CH_W < 1)                      begin : g_bad_ch    $error("acq_scan_seq: CH_W must be at least 1"); end
      if (ENTRY_W != entry_width(CH_W))  begin : g_bad_ent   $error("acq_scan_seq: entry width mismatch"); end
   endgenerate

   logic               trig;
   logic [IDX_W-1:0]   rd_idx;
   logic [ENTRY_W-1:0] rd_entry;

   acq_scan_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ext_trig_ni (ext_trig_ni),
      .bus_mode_i  (bus_mode_i),
      .ext_dis_i   (ext_dis_i),
      .start_wr_i  (start_wr_i),
      .bus_trig_i  (bus_trig_i),
      .trig_o      (trig)
   );

   acq_scan_cfg_mem #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_mem (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (cfg_we_i),
      .wdata_i    (cfg_data_i),
      .wptr_clr_i (wptr_clr_i),
      .lock_i     (running_o),
      .rd_idx_i   (rd_idx),
      .rd_data_o  (rd_entry)
   );

   acq_scan_run #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CH_W(CH_W)) u_run (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .trig_i       (trig),
      .retrig_dis_i (retrig_dis_i),
      .ack_i        (ack_i),
      .tick_i       (tick_i),
      .conv_done_i  (conv_done_i),
      .cnt_load_i   (cnt_load_i),
      .cnt_value_i  (cnt_value_i),
      .entry_i      (rd_entry),
      .idx_o        (rd_idx),
      .conv_req_o   (conv_req_o),
      .chan_o       (chan_o),
      .gain_o       (gain_o),
      .range_o      (range_o),
      .busy_o       (busy_o),
      .running_o    (running_o),
      .in_prog_o    (in_prog_o),
      .overrun_o    (overrun_o)
   );
endmodule

// File: rtl/acq_scan_seq_chk.sv
module acq_scan_seq_chk #(
   parameter int unsigned CH_W = 6
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            ack_i,
   input logic            tick_i,
   input logic            conv_done_i,
   input logic            conv_req_o,
   input logic [CH_W-1:0] chan_o,
   input logic [2:0]      gain_o,
   input logic            busy_o,
   input logic            running_o,
   input logic            in_prog_o,
   input logic            overrun_o
);
   p_req_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_req_o |-> busy_o);
   p_done_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && conv_done_i) |=> !busy_o);
   p_req_in_run_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_req_o |-> running_o);
   p_idle_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!running_o && tick_i) |=> !conv_req_o);
   p_ovr_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (overrun_o && !ack_i) |=> overrun_o);
   p_req_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_req_o |=> !conv_req_o);
   p_gain_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !conv_req_o |-> ($stable(gain_o) && $stable(chan_o)));
   p_run_prog_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      running_o |-> in_prog_o);
endmodule

bind acq_scan_seq acq_scan_seq_chk #(.CH_W(CH_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .ack_i       (ack_i),
   .tick_i      (tick_i),
   .conv_done_i (conv_done_i),
   .conv_req_o  (conv_req_o),
   .chan_o      (chan_o),
   .gain_o      (gain_o),
   .busy_o      (busy_o),
   .running_o   (running_o),
   .in_prog_o   (in_prog_o),
   .overrun_o   (overrun_o)
);

// File: tb/acq_scan_seq_tb_top.sv
`timescale 1ns/100ps
module acq_scan_seq_tb_top;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0, wptr_clr = 0, cnt_load = 0;
   logic [10:0] cfg_data = '0;
   logic [15:0] cnt_value = '0;
   logic        bus_mode = 0, ext_dis = 0, retrig_dis = 0, start_wr = 0;
   logic        ext_n = 1, bus_trig = 0, ack = 0, tick = 0, done = 0;
   logic        conv_req, range_o, busy, running, in_prog, overrun;
   logic [5:0]  chan;
   logic [2:0]  gain;

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   acq_scan_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_data_i(cfg_data),
      .wptr_clr_i(wptr_clr), .cnt_load_i(cnt_load), .cnt_value_i(cnt_value),
      .bus_mode_i(bus_mode), .ext_dis_i(ext_dis), .retrig_dis_i(retrig_dis),
      .start_wr_i(start_wr), .ext_trig_ni(ext_n), .bus_trig_i(bus_trig),
      .ack_i(ack), .tick_i(tick), .conv_done_i(done), .conv_req_o(conv_req),
      .chan_o(chan), .gain_o(gain), .range_o(range_o), .busy_o(busy),
      .running_o(running), .in_prog_o(in_prog), .overrun_o(overrun)
   );

   // ---------------- behavioural reference model ----------------
   int m_mem [DEPTH];
   int m_wptr, m_reload, m_idx, m_rem;
   bit m_run, m_final, m_busy, m_req, m_rng, m_prog, m_ovr;
   int m_chan, m_gain;
   bit e1, e2, e3;

   always @(posedge clk) begin
      bit fall, trg, acc, iss, fin;
      int ent;
      if (!rst_n) begin
         foreach (m_mem[k]) m_mem[k] = 0;
         m_wptr = 0; m_reload = 0; m_idx = 0; m_rem = 0;
         m_run = 0; m_final = 0; m_busy = 0; m_req = 0; m_rng = 0;
         m_prog = 0; m_ovr = 0; m_chan = 0; m_gain = 0;
         e1 = 1; e2 = 1; e3 = 1;
      end else begin
         fall = e3 && !e2;
         trg  = bus_mode ? bus_trig : (start_wr || (fall && !ext_dis));
         acc  = trg && !m_run && !(retrig_dis && m_prog);
         iss  = tick && m_run && !m_busy && !m_final;
         fin  = done && m_busy && m_final;
         ent  = m_mem[m_idx];
         // status flags (use old run state)
         if (tick && m_run && m_busy) m_ovr = 1; else if (ack) m_ovr = 0;
         if (acc) m_prog = 1; else if (ack && !m_run) m_prog = 0;
         // scan list writes
         if (cfg_we && !m_run) m_mem[m_wptr] = int'(cfg_data);
         if (wptr_clr) m_wptr = 0;
         else if (cfg_we && !m_run) m_wptr = (m_wptr + 1) % DEPTH;
         if (cnt_load) m_reload = int'(cnt_value);
         // conversion path
         m_req = iss;
         if (iss) begin
            m_busy = 1; m_chan = ent & 63; m_gain = (ent >> 6) & 7; m_rng = ent[9];
         end else if (done) m_busy = 0;
         // run control
         if (acc) begin
            m_run = 1; m_final = 0; m_rem = m_reload; m_idx = 0;
         end else begin
            if (fin) begin m_run = 0; m_final = 0; end
            if (iss) begin
               if (m_rem == 0) m_final = 1; else m_rem = m_rem - 1;
               m_idx = (ent[10] || m_idx == DEPTH - 1) ? 0 : m_idx + 1;
            end
         end
         e3 = e2; e2 = e1; e1 = ext_n;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // compare every output with the model at each falling edge
   always @(negedge clk) if (rst_n) begin
      chk("R1 model conv_req", conv_req, m_req);
      chk("R1 model chan",     chan,     m_chan);
      chk("R1 model gain",     gain,     m_gain);
      chk("R1 model range",    range_o,  m_rng);
      chk("R8 model busy",     busy,     m_busy);
      chk("R7 model running",  running,  m_run);
      chk("R6 model in_prog",  in_prog,  m_prog);
      chk("R10 model overrun", overrun,  m_ovr);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !finished) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [10:0] mk(input int c, input int g, input bit r, input bit l);
      return {l, r, 3'(g), 6'(c)};
   endfunction

   task automatic wr(input logic [10:0] d);
      @(negedge clk) cfg_we = 1; cfg_data = d;
      @(negedge clk) cfg_we = 0;
   endtask

   task automatic conv(input int ec, input int eg, input bit ovr_try);
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      chk("R1 conv_req pulse", conv_req, 1);
      chk("R2 channel order", chan, ec);
      chk("R1 gain code", gain, eg);
      if (ovr_try) begin
         tick = 1;
         @(negedge clk) tick = 0;
         chk("R10 overrun on busy tick", overrun, 1);
         chk("R10 no request while busy", conv_req, 0);
      end
      done = 1;
      @(negedge clk) done = 0;
      chk("R8 busy cleared by done", busy, 0);
   endtask

   task automatic pulse_start();
      @(negedge clk) start_wr = 1;
      @(negedge clk) start_wr = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R11 reset conv_req", conv_req, 0);
      chk("R11 reset running", running, 0);
      chk("R11 reset busy", busy, 0);
      chk("R11 reset in_prog", in_prog, 0);
      chk("R11 reset chan", chan, 0);

      // tick outside a run
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      chk("R10 idle tick ignored", conv_req, 0);

      wr(mk(5, 1, 0, 0));
      wr(mk(12, 3, 1, 0));
      wr(mk(33, 7, 0, 1));
      @(negedge clk) cnt_load = 1; cnt_value = 16'd6;
      @(negedge clk) cnt_load = 0;

      // run 1: software start, 7 samples, wrap on end-of-list flag
      pulse_start();
      chk("R4 start strobe runs", running, 1);
      chk("R6 in_prog set", in_prog, 1);
      conv(5, 1, 0); chk("R1 range entry0", range_o, 0);
      conv(12, 3, 0); chk("R1 range entry1", range_o, 1);
      conv(33, 7, 0);
      conv(5, 1, 0);
      conv(12, 3, 0);
      conv(33, 7, 0);
      chk("R7 still running before last", running, 1);
      conv(5, 1, 0);
      chk("R7 run ends after N samples", running, 0);
      chk("R6 in_prog holds after run", in_prog, 1);

      // lockout
      @(negedge clk) retrig_dis = 1;
      pulse_start();
      chk("R6 lockout refuses trigger", running, 0);
      @(negedge clk) ack = 1;
      @(negedge clk) ack = 0;
      chk("R6 ack clears in_prog", in_prog, 0);
      pulse_start();
      chk("R7 rerun without reload", running, 1);
      // writes during the run are ignored
      @(negedge clk) wptr_clr = 1;
      @(negedge clk) wptr_clr = 0;
      wr(mk(60, 2, 0, 1));
      pulse_start();
      chk("R6 trigger during run ignored", running, 1);
      conv(5, 1, 1);
      conv(12, 3, 0);
      conv(33, 7, 0);
      conv(5, 1, 0);
      conv(12, 3, 0);
      conv(33, 7, 0);
      conv(5, 1, 0);
      chk("R7 second run ends", running, 0);
      chk("R10 overrun sticky", overrun, 1);
      @(negedge clk) ack = 1; retrig_dis = 0;
      @(negedge clk) ack = 0;
      chk("R10 ack clears overrun", overrun, 0);

      // external trigger, disabled then enabled
      @(negedge clk) cnt_load = 1; cnt_value = 16'd1;
      @(negedge clk) cnt_load = 0; ext_dis = 1; ext_n = 0;
      repeat (5) @(negedge clk);
      chk("R5 disabled edge ignored", running, 0);
      ext_n = 1; ext_dis = 0;
      repeat (4) @(negedge clk);
      ext_n = 0;
      @(negedge clk); @(negedge clk);
      chk("R4 sync delay not yet", running, 0);
      @(negedge clk);
      chk("R4 external fall starts run", running, 1);
      ext_n = 1;
      conv(5, 1, 0);
      chk("R9 write during run ignored", chan, 5);
      conv(12, 3, 0);
      chk("R7 two-sample run ends", running, 0);

      // bus mode
      @(negedge clk) bus_mode = 1;
      pulse_start();
      chk("R3 start ignored in bus mode", running, 0);
      @(negedge clk) ext_n = 0;
      repeat (4) @(negedge clk);
      chk("R3 external ignored in bus mode", running, 0);
      ext_n = 1;
      repeat (3) @(negedge clk);
      @(negedge clk) bus_trig = 1;
      @(negedge clk) bus_trig = 0;
      chk("R3 bus trigger starts run", running, 1);
      conv(5, 1, 0);
      conv(12, 3, 0);
      chk("R3 bus run ends", running, 0);

      // idle write after pointer clear
      @(negedge clk) wptr_clr = 1;
      @(negedge clk) wptr_clr = 0;
      wr(mk(60, 2, 1, 1));
      @(negedge clk) bus_trig = 1;
      @(negedge clk) bus_trig = 0;
      conv(60, 2, 0);
      chk("R9 idle write lands at entry 0", chan, 60);
      conv(60, 2, 0);
      chk("R2 single-entry list wraps", running, 0);

      repeat (3) @(negedge clk);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule